// File: doc/BRIEF.md
# Five-Operation 64-bit Arithmetic Unit

This block is a stateless arithmetic unit. It takes two 64-bit operands and a 3-bit operation code, and it returns one 64-bit result. The operations are addition, subtraction, multiplication, logical left shift and logical right shift. A processor datapath uses it for two jobs: computing data results, and forming addresses such as base plus offset. The unit has no clock, no storage and no flag outputs, so the result settles from the inputs alone.

Addition, subtraction and multiplication wrap modulo 2^64. Multiplication returns only the low half of the product. The two shifts take their distance from the low six bits of the second operand and fill the vacated positions with zeros. The three unassigned operation codes return zero.

Internally one adder serves both addition and subtraction, and one barrel shifter serves both shift directions by mirroring its data. A build parameter selects how the multiplier is built: either as an operator for the synthesis tool to map, or as an explicit shift-and-add array.

Top module: `calc_unit64`

## Requirements
- R1: Operation code 3'b000 returns opa + opb modulo 2^64; with both operands zero the result is zero.
- R2: Operation code 3'b001 returns opa - opb modulo 2^64 (for example 0 - 1 gives all ones).
- R3: Operation code 3'b010 returns the low 64 bits of the unsigned product opa * opb.
- R4: Operation code 3'b011 returns opa shifted left by the shift distance, with zeros entering at bit 0.
- R5: Operation code 3'b100 returns opa shifted right by the shift distance, with zeros entering at bit 63.
- R6: The shift distance is opb[5:0] (in general, the low log2(width) bits of opb), and the upper bits of opb do not change a shift result.
- R7: Operation codes 3'b101, 3'b110 and 3'b111 return zero for any operands.
- R8: The result is a pure function of the present inputs; it follows an input change without any clock edge.
- R9: Both multiplier build choices (operator or shift-and-add array) give the same result for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 64 | First operand; the value that is shifted |
| opb_i | input | 64 | Second operand; its low bits give the shift distance |
| opc_i | input | 3 | Operation code |
| res_o | output | 64 | Result |

## Verification
The unit holds no state, so a wrong internal net shows up at res_o for the same input vector, within the settling delay, and leaves no trace once the inputs change. A fault in the shared adder shows on both the add and subtract codes. A fault in one stage of the shifter shows only at distances that have that bit set, and a fault in the mirroring logic shows only on right shifts. This is why the bench sweeps every distance and every operation code, and runs an exhaustive sweep on a narrow build, where each of these paths is reached for every input.

// File: rtl/calc_pkg.sv
package calc_pkg;

  localparam int unsigned OPC_W  = 3;
  localparam int unsigned N_FUNC = 5;

  localparam logic [OPC_W-1:0] OPC_ADD = 3'b000;
  localparam logic [OPC_W-1:0] OPC_SUB = 3'b001;
  localparam logic [OPC_W-1:0] OPC_MUL = 3'b010;
  localparam logic [OPC_W-1:0] OPC_SHL = 3'b011;
  localparam logic [OPC_W-1:0] OPC_SHR = 3'b100;

  // Index of each function unit in the one-hot select vector.
  localparam int unsigned F_ADD = 0;
  localparam int unsigned F_SUB = 1;
  localparam int unsigned F_MUL = 2;
  localparam int unsigned F_SHL = 3;
  localparam int unsigned F_SHR = 4;

  // One-hot decode; an unassigned code yields an all-zero vector.
  function automatic logic [N_FUNC-1:0] opc_onehot(input logic [OPC_W-1:0] opc);
    logic [N_FUNC-1:0] oh;
    for (int i = 0; i < int'(N_FUNC); i++) begin
      oh[i] = (opc == OPC_W'(i));
    end
    return oh;
  endfunction

endpackage

// File: rtl/calc_addsub.sv
module calc_addsub #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         neg_i,
  output logic [W-1:0] sum_o
);

  // Two's complement: x - y = x + ~y + 1
  function automatic logic [W-1:0] add_ci(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         ci);
    return x + y + W'(ci);
  endfunction

  logic [W-1:0] y_eff;

  always_comb begin
    y_eff = neg_i ? ~y_i : y_i;
    sum_o = add_ci(x_i, y_eff, neg_i);
  end

endmodule

// File: rtl/calc_mul.sv
module calc_mul #(
  parameter int unsigned W     = 64,
  parameter bit          ARRAY = 1'b0
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] prod_o
);

  function automatic logic [W-1:0] mul_lo(input logic [W-1:0] x,
                                          input logic [W-1:0] y);
    return x * y;
  endfunction

  function automatic logic [W-1:0] pp_add(input logic [W-1:0] acc,
                                          input logic [W-1:0] x,
                                          input logic         bit_y,
                                          input int unsigned  sh);
    return acc + (bit_y ? (x << sh) : '0);
  endfunction

  generate
    if (ARRAY) begin : g_array
      logic [W-1:0] acc [0:W];
      assign acc[0] = '0;
      for (genvar k = 0; k < int'(W); k++) begin : g_row
        assign acc[k+1] = pp_add(acc[k], x_i, y_i[k], k);
      end
      assign prod_o = acc[W];
    end else begin : g_oper
      assign prod_o = mul_lo(x_i, y_i);
    end
  endgenerate

endmodule

// File: rtl/calc_shift.sv
module calc_shift #(
  parameter int unsigned W    = 64,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    d_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            right_i,
  output logic [W-1:0]    q_o
);

  function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < int'(W); i++) begin
      r[i] = v[W-1-i];
    end
    return r;
  endfunction

  logic [W-1:0] stg [0:SH_W];

  // A right shift is a left shift of the mirrored word, mirrored back.
  assign stg[0] = right_i ? mirror(d_i) : d_i;

  generate
    for (genvar k = 0; k < int'(SH_W); k++) begin : g_stage
      assign stg[k+1] = amt_i[k] ? (stg[k] << (1 << k)) : stg[k];
    end
  endgenerate

  assign q_o = right_i ? mirror(stg[SH_W]) : stg[SH_W];

endmodule

// File: rtl/calc_sel.sv
module calc_sel #(
  parameter int unsigned W = 64,
  parameter int unsigned N = 5
) (
  input  logic [N-1:0]        oh_i,
  input  logic [N-1:0][W-1:0] res_i,
  output logic [W-1:0]        q_o
);

  always_comb begin
    q_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      q_o = q_o | ({W{oh_i[i]}} & res_i[i]);
    end
  end

endmodule

// File: rtl/calc_unit64.sv
module calc_unit64
  import calc_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter bit          MUL_ARRAY = 1'b0
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [OPC_W-1:0]  opc_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [N_FUNC-1:0]             fsel_w;
  logic [DATA_W-1:0]             sum_w;
  logic [DATA_W-1:0]             prod_w;
  logic [DATA_W-1:0]             shift_w;
  logic [SH_W-1:0]               shamt_w;
  logic [N_FUNC-1:0][DATA_W-1:0] unit_res;

  assign fsel_w  = opc_onehot(opc_i);
  assign shamt_w = opb_i[SH_W-1:0];

  calc_addsub #(.W(DATA_W)) u_addsub (
    .x_i   (opa_i),
    .y_i   (opb_i),
    .neg_i (fsel_w[F_SUB]),
    .sum_o (sum_w)
  );

  calc_mul #(.W(DATA_W), .ARRAY(MUL_ARRAY)) u_mul (
    .x_i    (opa_i),
    .y_i    (opb_i),
    .prod_o (prod_w)
  );

  calc_shift #(.W(DATA_W), .SH_W(SH_W)) u_shift (
    .d_i     (opa_i),
    .amt_i   (shamt_w),
    .right_i (fsel_w[F_SHR]),
    .q_o     (shift_w)
  );

  always_comb begin
    unit_res        = '0;
    unit_res[F_ADD] = sum_w;
    unit_res[F_SUB] = sum_w;
    unit_res[F_MUL] = prod_w;
    unit_res[F_SHL] = shift_w;
    unit_res[F_SHR] = shift_w;
  end

  calc_sel #(.W(DATA_W), .N(N_FUNC)) u_sel (
    .oh_i  (fsel_w),
    .res_i (unit_res),
    .q_o   (res_o)
  );

endmodule

// File: rtl/calc_unit64_chk.sv
module calc_unit64_chk
  import calc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input logic [W-1:0]      opa,
  input logic [W-1:0]      opb,
  input logic [OPC_W-1:0]  opc,
  input logic [W-1:0]      res,
  input logic [W-1:0]      sum_w,
  input logic [N_FUNC-1:0] fsel
);

  localparam int unsigned SH_W = $clog2(W);

  always_comb begin
    // R1
    add_wrap_chk: assert (opc != OPC_ADD || res == W'(opa + opb));
    // R2
    sub_inverse_chk: assert (opc != OPC_SUB || W'(res + opb) == opa);
    // R3
    mul_unit_chk: assert (opc != OPC_MUL || opb != W'(1) || res == opa);
    // R3
    mul_zero_chk: assert (opc != OPC_MUL || opb != '0 || res == '0);
    // R4
    shl_fill_chk: assert (opc != OPC_SHL || opb[SH_W-1:0] == '0 || res[0] == 1'b0);
    // R5
    shr_fill_chk: assert (opc != OPC_SHR || opb[SH_W-1:0] == '0 || res[W-1] == 1'b0);
    // R6
    shift_zero_dist_chk: assert (!(opc == OPC_SHL || opc == OPC_SHR) || opb[SH_W-1:0] != '0 || res == opa);
    // R7
    undef_zero_chk: assert (opc <= OPC_SHR || (res == '0 && fsel == '0));
    // R7
    fsel_onehot_chk: assert ($onehot0(fsel));
    // R2
    addsub_share_chk: assert (!(opc == OPC_ADD || opc == OPC_SUB) || res == sum_w);
  end

endmodule

bind calc_unit64 calc_unit64_chk #(.W(DATA_W)) u_chk (
  .opa   (opa_i),
  .opb   (opb_i),
  .opc   (opc_i),
  .res   (res_o),
  .sum_w (sum_w),
  .fsel  (fsel_w)
);

// File: tb/sim_calc_unit64.sv
module sim_calc_unit64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [63:0] a64, b64, r64;
  logic [2:0]  op64;
  logic [7:0]  a8, b8, r8, r8_arr;
  logic [2:0]  op8;

  calc_unit64 u0 (.opa_i(a64), .opb_i(b64), .opc_i(op64), .res_o(r64));
  calc_unit64 #(.DATA_W(8)) u_small (.opa_i(a8), .opb_i(b8), .opc_i(op8), .res_o(r8));
  calc_unit64 #(.DATA_W(8), .MUL_ARRAY(1'b1)) u_arr (.opa_i(a8), .opb_i(b8), .opc_i(op8), .res_o(r8_arr));

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [63:0] ref64(input int op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] p;
    int s;
    s = int'(b % 64);
    p = a;
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      3: begin repeat (s) p = p * 2; return p; end
      4: begin repeat (s) p = p / 2; return p; end
      default: return 64'd0;
    endcase
  endfunction

  function automatic int ref8(input int op, input int a, input int b);
    int s;
    s = b % 8;
    case (op)
      0: return (a + b) % 256;
      1: return (a - b + 256) % 256;
      2: return (a * b) % 256;
      3: return (a * (2 ** s)) % 256;
      4: return a / (2 ** s);
      default: return 0;
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] exp);
    total++;
    if (r64 !== exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op64, a64, b64, r64, exp);
    end
  endtask

  task automatic run64(input int op, input logic [63:0] a, input logic [63:0] b);
    op64 = 3'(op); a64 = a; b64 = b;
    #1;
    check64(tag_of(op), ref64(op, a, b));
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr_a, lfsr_b;
    a64 = '0; b64 = '0; op64 = 3'd0;
    a8 = '0; b8 = '0; op8 = 3'd0;
    @(negedge clk);
    #1;
    // R1: all-zero inputs give zero
    check64("R1", 64'd0);

    // R1..R5, R7: corner operands, every opcode
    for (int op = 0; op < 8; op++) begin
      run64(op, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
      run64(op, 64'd0, 64'd1);
      run64(op, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
      run64(op, 64'hAAAA_5555_F0F0_0F0F, 64'd63);
      run64(op, 64'h0123_4567_89AB_CDEF, 64'd0);
    end

    // R4, R5, R6: every shift distance, with junk in the upper bits of opb
    for (int s = 0; s < 64; s++) begin
      run64(3, 64'hDEAD_BEEF_0BAD_F00D, 64'(s));
      run64(4, 64'hDEAD_BEEF_0BAD_F00D, 64'(s));
      op64 = 3'd3; a64 = 64'hFFFF_FFFF_FFFF_FFFF; b64 = {58'h2A5_5A5A_5A5A_5A5, 6'(s)};
      #1;
      check64("R6", ref64(3, a64, 64'(s)));
      op64 = 3'd4;
      #1;
      check64("R6", ref64(4, a64, 64'(s)));
    end

    // R1..R7: pseudo-random operands
    lfsr_a = 64'h1357_9BDF_2468_ACE0;
    lfsr_b = 64'h0F1E_2D3C_4B5A_6978;
    for (int n = 0; n < 200; n++) begin
      lfsr_a = lfsr_a ^ (lfsr_a << 13); lfsr_a = lfsr_a ^ (lfsr_a >> 7); lfsr_a = lfsr_a ^ (lfsr_a << 17);
      lfsr_b = lfsr_b ^ (lfsr_b << 13); lfsr_b = lfsr_b ^ (lfsr_b >> 7); lfsr_b = lfsr_b ^ (lfsr_b << 17);
      for (int op = 0; op < 8; op++) run64(op, lfsr_a, lfsr_b);
    end

    // R8: result follows an input change mid-cycle with no clock edge
    @(posedge clk);
    #2;
    op64 = 3'd0; a64 = 64'd40; b64 = 64'd2;
    #1;
    check64("R8", 64'd42);
    a64 = 64'd100;
    #1;
    check64("R8", 64'd102);
    op64 = 3'd1;
    #1;
    check64("R8", 64'd98);

    // Exhaustive sweep of the 8-bit build: R1..R7, and R9 for the array multiplier
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          op8 = 3'(op); a8 = 8'(a); b8 = 8'(b);
          #1;
          total++;
          if (int'(r8) != ref8(op, a, b)) begin
            bad++;
            $display("FAIL %s narrow op=%0d a=%0d b=%0d actual=%0d expected=%0d",
                     tag_of(op), op, a, b, r8, ref8(op, a, b));
          end
          if (op == 2) begin
            total++;
            if (int'(r8_arr) != ref8(op, a, b)) begin
              bad++;
              $display("FAIL R9 array mul a=%0d b=%0d actual=%0d expected=%0d",
                       a, b, r8_arr, ref8(op, a, b));
            end
          end
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule